// File: doc/BRIEF.md
# Low-Power and Debug Mode Controller

This block sequences a CPU core between four operating modes: normal execution, a light sleep that waits for an interrupt, a deep sleep in which clocks may be stopped, and a halted debug mode in which a host owns the core. Its inputs are events that other logic has already decoded: the sleep and break opcodes from the instruction decoder, a hardware breakpoint hit, a pending interrupt, reset requests, the level of the debug pin when reset ends, and debug commands from a serial front end. Its outputs are the CPU clock enable, the oscillator keep-alive, a one-cycle strobe that clears the interrupt mask, and a two-bit mode code.

Internally the sequencer has five states. S_RUN executes user code. S_STEP also executes user code, but only for a single traced instruction. S_WAIT is light sleep. S_STOP is deep sleep. S_DBG is active debug. The named transitions are as follows. sleep_enter goes from S_RUN to S_WAIT on a wait opcode. deep_enter goes from S_RUN to S_STOP on a stop opcode. break_enter goes from S_RUN or S_STEP to S_DBG on a break command, break opcode or breakpoint. irq_wake goes from S_WAIT or S_STOP to S_RUN. host_wake goes from S_WAIT or S_STOP to S_DBG on a break command. resume goes from S_DBG to S_RUN on a go or tagged-go command. step_start goes from S_DBG to S_STEP on a trace command. step_done goes from S_STEP to S_DBG when an instruction completes. reset_exit leaves the reset hold for S_RUN or S_DBG.

Top module: `mode_ctl`

## Requirements
- R1: A wait event in S_RUN moves the core to light sleep. `imask_clr` is high for exactly one cycle, the first cycle of light sleep.
- R2: `cpu_clk_en` is low in light sleep and deep sleep. It is high in run, step and debug, and while reset is held.
- R3: A pending interrupt in light sleep returns the core to run on the next edge. In deep sleep it does the same when STOP_IRQ_WAKE is 1.
- R4: `osc_en` is low in deep sleep when `dbg_en` is 0. It is high in deep sleep when `dbg_en` is 1, and high in every other mode.
- R5: A break command in light sleep moves the core to debug on the next edge, taking precedence over a pending interrupt.
- R6: A break command in deep sleep moves the core to debug only when `dbg_en` is 1. Otherwise it is ignored and the core stays in deep sleep.
- R7: In run, a break command, break opcode or breakpoint hit moves the core to debug. These take precedence over the stop and wait events, and stop takes precedence over wait.
- R8: While `rst_n` is low the mode is run. On the first rising edge after release the core enters debug if `dbg_pin_low` is 1 at that edge, and run otherwise. Events at that edge are ignored.
- R9: `reset_req` has priority over every other input. It holds the core in reset like `rst_n` does, and the reset exit of R8 follows on the first edge after it drops.
- R10: Debug is left only through go or tagged go, which lead to run, or trace, which leads to step. Interrupts, sleep events and breaks leave debug unchanged.
- R11: In step the mode reads run. On the edge where `insn_done` is 1 the core returns to debug.
- R12: `mode` encodes run and step as 2'b00, light sleep as 2'b01, deep sleep as 2'b10 and debug as 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_req | input | 1 | Synchronous reset request, active high |
| dbg_pin_low | input | 1 | Debug pin held low; sampled on reset exit |
| dbg_en | input | 1 | Debug enable control bit (level) |
| ev_wait | input | 1 | Wait opcode executed |
| ev_stop | input | 1 | Stop opcode executed |
| ev_brk_op | input | 1 | Break opcode executed |
| bkpt_hit | input | 1 | Hardware breakpoint match |
| irq_pend | input | 1 | Interrupt pending |
| insn_done | input | 1 | One user instruction completed |
| cmd_break | input | 1 | Host break command |
| cmd_go | input | 1 | Host resume command |
| cmd_trace | input | 1 | Host single-step command |
| cmd_taggo | input | 1 | Host tagged resume command |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator keep-alive |
| imask_clr | output | 1 | One-cycle strobe that clears the interrupt mask |
| mode | output | 2 | Current mode code |

## Verification
The bench builds the block with the default STOP_IRQ_WAKE = 1. This puts the irq_wake path out of deep sleep within reach of the random phase, next to host_wake and the ignored break when `dbg_en` is low. With that value every transition named above can occur under random stimulus. Directed sequences pin down the reset-exit pin sampling, the single-step return, and the priority of break over interrupt in light sleep.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [2:0] {
        S_RUN  = 3'd0,
        S_STEP = 3'd1,
        S_WAIT = 3'd2,
        S_STOP = 3'd3,
        S_DBG  = 3'd4
    } state_t;

    localparam logic [MODE_W-1:0] MD_RUN  = 2'b00;
    localparam logic [MODE_W-1:0] MD_WAIT = 2'b01;
    localparam logic [MODE_W-1:0] MD_STOP = 2'b10;
    localparam logic [MODE_W-1:0] MD_DBG  = 2'b11;
endpackage

// File: rtl/mode_next.sv
module mode_next
    import mode_ctl_pkg::*;
#(
    parameter bit STOP_IRQ_WAKE = 1'b1
) (
    input  state_t state,
    input  logic   in_rst,
    input  logic   reset_req,
    input  logic   dbg_pin_low,
    input  logic   dbg_en,
    input  logic   ev_wait,
    input  logic   ev_stop,
    input  logic   ev_brk_op,
    input  logic   bkpt_hit,
    input  logic   irq_pend,
    input  logic   insn_done,
    input  logic   cmd_break,
    input  logic   cmd_go,
    input  logic   cmd_trace,
    input  logic   cmd_taggo,
    output state_t nxt,
    output logic   nxt_in_rst
);
    logic brk_any;

    always_comb begin
        brk_any    = cmd_break | ev_brk_op | bkpt_hit;
        nxt        = state;
        nxt_in_rst = 1'b0;
        if (reset_req) begin
            nxt        = S_RUN;
            nxt_in_rst = 1'b1;
        end else if (in_rst) begin
            nxt = dbg_pin_low ? S_DBG : S_RUN;
        end else begin
            unique case (state)
                S_RUN: begin
                    if (brk_any)      nxt = S_DBG;
                    else if (ev_stop) nxt = S_STOP;
                    else if (ev_wait) nxt = S_WAIT;
                end
                S_STEP: begin
                    if (brk_any || insn_done) nxt = S_DBG;
                end
                S_WAIT: begin
                    if (cmd_break)     nxt = S_DBG;
                    else if (irq_pend) nxt = S_RUN;
                end
                S_STOP: begin
                    if (cmd_break && dbg_en)           nxt = S_DBG;
                    else if (irq_pend && STOP_IRQ_WAKE) nxt = S_RUN;
                end
                S_DBG: begin
                    if (cmd_go || cmd_taggo) nxt = S_RUN;
                    else if (cmd_trace)      nxt = S_STEP;
                end
                default: nxt = S_RUN;
            endcase
        end
    end
endmodule

// File: rtl/mode_outputs.sv
module mode_outputs
    import mode_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  state_t            state,
    input  state_t            nxt,
    input  logic              dbg_en,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic              imask_clr,
    output logic [MODE_W-1:0] mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) imask_clr <= 1'b0;
        else        imask_clr <= (nxt == S_WAIT) && (state != S_WAIT);
    end

    always_comb begin
        cpu_clk_en = 1'b1;
        osc_en     = 1'b1;
        mode       = MD_RUN;
        unique case (state)
            S_RUN, S_STEP: mode = MD_RUN;
            S_WAIT: begin
                mode       = MD_WAIT;
                cpu_clk_en = 1'b0;
            end
            S_STOP: begin
                mode       = MD_STOP;
                cpu_clk_en = 1'b0;
                osc_en     = dbg_en;
            end
            S_DBG:   mode = MD_DBG;
            default: mode = MD_RUN;
        endcase
    end
endmodule

// File: rtl/mode_ctl.sv
module mode_ctl
    import mode_ctl_pkg::*;
#(
    parameter bit STOP_IRQ_WAKE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              dbg_pin_low,
    input  logic              dbg_en,
    input  logic              ev_wait,
    input  logic              ev_stop,
    input  logic              ev_brk_op,
    input  logic              bkpt_hit,
    input  logic              irq_pend,
    input  logic              insn_done,
    input  logic              cmd_break,
    input  logic              cmd_go,
    input  logic              cmd_trace,
    input  logic              cmd_taggo,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic              imask_clr,
    output logic [MODE_W-1:0] mode
);
    state_t state, nxt;
    logic   in_rst, nxt_in_rst;

    mode_next #(.STOP_IRQ_WAKE(STOP_IRQ_WAKE)) u_next (
        .state(state), .in_rst(in_rst), .reset_req(reset_req),
        .dbg_pin_low(dbg_pin_low), .dbg_en(dbg_en),
        .ev_wait(ev_wait), .ev_stop(ev_stop), .ev_brk_op(ev_brk_op),
        .bkpt_hit(bkpt_hit), .irq_pend(irq_pend), .insn_done(insn_done),
        .cmd_break(cmd_break), .cmd_go(cmd_go), .cmd_trace(cmd_trace),
        .cmd_taggo(cmd_taggo), .nxt(nxt), .nxt_in_rst(nxt_in_rst)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_RUN;
            in_rst <= 1'b1;
        end else begin
            state  <= nxt;
            in_rst <= nxt_in_rst;
        end
    end

    mode_outputs u_out (
        .clk(clk), .rst_n(rst_n), .state(state), .nxt(nxt), .dbg_en(dbg_en),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .imask_clr(imask_clr),
        .mode(mode)
    );
endmodule

// File: rtl/mode_ctl_chk.sv
module mode_ctl_chk
    import mode_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reset_req,
    input logic              dbg_en,
    input logic              irq_pend,
    input logic              cmd_break,
    input logic              cmd_go,
    input logic              cmd_trace,
    input logic              cmd_taggo,
    input logic              cpu_clk_en,
    input logic              osc_en,
    input logic              imask_clr,
    input logic [MODE_W-1:0] mode
);
    p_imask_first_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
        imask_clr |-> (mode == MD_WAIT) && ($past(mode) != MD_WAIT));

    p_clk_off_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_WAIT || mode == MD_STOP) |-> !cpu_clk_en);

    p_osc_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_STOP || dbg_en) |-> osc_en);

    p_stop_break_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STOP && !dbg_en && !irq_pend && !reset_req) |=> (mode == MD_STOP));

    p_dbg_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_DBG && !cmd_go && !cmd_trace && !cmd_taggo && !reset_req)
        |=> (mode == MD_DBG));

    p_wait_break_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_WAIT && cmd_break && !reset_req) |=> (mode == MD_DBG));
endmodule

bind mode_ctl mode_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .dbg_en(dbg_en),
    .irq_pend(irq_pend), .cmd_break(cmd_break), .cmd_go(cmd_go),
    .cmd_trace(cmd_trace), .cmd_taggo(cmd_taggo), .cpu_clk_en(cpu_clk_en),
    .osc_en(osc_en), .imask_clr(imask_clr), .mode(mode)
);

// File: tb/mode_ctl_bench.sv
module mode_ctl_bench;
    localparam logic [1:0] E_RUN = 2'b00, E_WAIT = 2'b01, E_STOP = 2'b10, E_DBG = 2'b11;
    localparam int M_RUN = 0, M_STEP = 1, M_WAIT = 2, M_STOP = 3, M_DBG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_req, dbg_pin_low, dbg_en, ev_wait, ev_stop, ev_brk_op, bkpt_hit;
    logic irq_pend, insn_done, cmd_break, cmd_go, cmd_trace, cmd_taggo;
    logic cpu_clk_en, osc_en, imask_clr;
    logic [1:0] mode;
    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    mode_ctl u_mode_ctl (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .dbg_pin_low(dbg_pin_low),
        .dbg_en(dbg_en), .ev_wait(ev_wait), .ev_stop(ev_stop), .ev_brk_op(ev_brk_op),
        .bkpt_hit(bkpt_hit), .irq_pend(irq_pend), .insn_done(insn_done),
        .cmd_break(cmd_break), .cmd_go(cmd_go), .cmd_trace(cmd_trace),
        .cmd_taggo(cmd_taggo), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .imask_clr(imask_clr), .mode(mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr_in();
        reset_req = 0; dbg_pin_low = 0; ev_wait = 0; ev_stop = 0; ev_brk_op = 0;
        bkpt_hit = 0; irq_pend = 0; insn_done = 0; cmd_break = 0; cmd_go = 0;
        cmd_trace = 0; cmd_taggo = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // reference next state built from the requirements
    function automatic int ref_next(input int s, input bit inr);
        if (reset_req) return M_RUN;
        if (inr) return dbg_pin_low ? M_DBG : M_RUN;
        case (s)
            M_RUN:  return (cmd_break | ev_brk_op | bkpt_hit) ? M_DBG :
                           ev_stop ? M_STOP : ev_wait ? M_WAIT : M_RUN;
            M_STEP: return (cmd_break | ev_brk_op | bkpt_hit | insn_done) ? M_DBG : M_STEP;
            M_WAIT: return cmd_break ? M_DBG : irq_pend ? M_RUN : M_WAIT;
            M_STOP: return (cmd_break && dbg_en) ? M_DBG : irq_pend ? M_RUN : M_STOP;
            default: return (cmd_go | cmd_taggo) ? M_RUN : cmd_trace ? M_STEP : M_DBG;
        endcase
    endfunction

    function automatic int ref_mode(input int s);
        case (s)
            M_WAIT:  return int'(E_WAIT);
            M_STOP:  return int'(E_STOP);
            M_DBG:   return int'(E_DBG);
            default: return int'(E_RUN);
        endcase
    endfunction

    initial begin : watchdog
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int ms, nx;
        bit mr;
        void'($urandom(32'd2024));
        clr_in(); dbg_en = 0;
        #35;
        chk("R8 mode in reset", int'(mode), int'(E_RUN));
        chk("R2 clk en in reset", int'(cpu_clk_en), 1);
        // R8: pin low at reset exit -> debug
        dbg_pin_low = 1; ev_wait = 1;
        @(negedge clk); rst_n = 1; #1;
        tick();
        chk("R8 pin low exit", int'(mode), int'(E_DBG));
        clr_in();
        // R10: debug ignores irq, wait, break
        irq_pend = 1; ev_wait = 1; cmd_break = 1; ev_stop = 1; tick();
        chk("R10 debug sticky", int'(mode), int'(E_DBG));
        clr_in();
        // R11: trace one instruction
        cmd_trace = 1; tick(); clr_in();
        chk("R11 step reads run", int'(mode), int'(E_RUN));
        tick();
        chk("R11 step holds", int'(mode), int'(E_RUN));
        insn_done = 1; tick(); clr_in();
        chk("R11 step returns", int'(mode), int'(E_DBG));
        cmd_go = 1; tick(); clr_in();
        chk("R10 go leaves debug", int'(mode), int'(E_RUN));
        // R1: wait entry strobe
        ev_wait = 1; tick(); clr_in();
        chk("R1 wait entered", int'(mode), int'(E_WAIT));
        chk("R12 wait code", int'(mode), 1);
        chk("R1 imask strobe", int'(imask_clr), 1);
        chk("R2 clk off wait", int'(cpu_clk_en), 0);
        tick();
        chk("R1 strobe one cycle", int'(imask_clr), 0);
        // R5: break beats irq in wait
        irq_pend = 1; cmd_break = 1; tick(); clr_in();
        chk("R5 break from wait", int'(mode), int'(E_DBG));
        cmd_taggo = 1; tick(); clr_in();
        chk("R10 tagged go", int'(mode), int'(E_RUN));
        // R7: stop beats wait
        ev_stop = 1; ev_wait = 1; tick(); clr_in();
        chk("R7 stop over wait", int'(mode), int'(E_STOP));
        chk("R4 osc off stop", int'(osc_en), 0);
        // R6: break ignored without dbg_en
        cmd_break = 1; tick(); clr_in();
        chk("R6 break ignored", int'(mode), int'(E_STOP));
        dbg_en = 1; #1;
        chk("R4 osc kept stop", int'(osc_en), 1);
        cmd_break = 1; tick(); clr_in();
        chk("R6 break with enable", int'(mode), int'(E_DBG));
        cmd_go = 1; tick(); clr_in();
        // R3: irq wake from stop
        ev_stop = 1; tick(); clr_in();
        irq_pend = 1; tick(); clr_in();
        chk("R3 irq wakes stop", int'(mode), int'(E_RUN));
        // R7: breakpoint beats stop
        bkpt_hit = 1; ev_stop = 1; tick(); clr_in();
        chk("R7 bkpt to debug", int'(mode), int'(E_DBG));
        // R9: sync reset with pin high -> run
        reset_req = 1; tick(); clr_in();
        chk("R9 reset held", int'(mode), int'(E_RUN));
        ev_stop = 1; tick(); clr_in();
        chk("R9 exit to run", int'(mode), int'(E_RUN));

        // random phase against the reference
        ms = M_RUN; mr = 0;
        for (int i = 0; i < 3000; i++) begin
            reset_req   = ($urandom % 80) == 0;
            dbg_pin_low = $urandom % 2;
            dbg_en      = ($urandom % 4) == 0;
            ev_wait     = ($urandom % 6) == 0;
            ev_stop     = ($urandom % 8) == 0;
            ev_brk_op   = ($urandom % 20) == 0;
            bkpt_hit    = ($urandom % 20) == 0;
            irq_pend    = ($urandom % 5) == 0;
            insn_done   = ($urandom % 3) == 0;
            cmd_break   = ($urandom % 10) == 0;
            cmd_go      = ($urandom % 6) == 0;
            cmd_trace   = ($urandom % 6) == 0;
            cmd_taggo   = ($urandom % 12) == 0;
            nx = ref_next(ms, mr);
            tick();
            chk("R12 random mode", int'(mode), ref_mode(nx));
            chk("R2 random clk", int'(cpu_clk_en), (nx == M_WAIT || nx == M_STOP) ? 0 : 1);
            chk("R4 random osc", int'(osc_en), (nx == M_STOP && !dbg_en) ? 0 : 1);
            chk("R1 random strobe", int'(imask_clr), (nx == M_WAIT && ms != M_WAIT) ? 1 : 0);
            mr = reset_req;
            ms = nx;
        end
        clr_in();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule